// File: doc/BRIEF.md
# Load reuse buffer with deferred store

This block sits between a vector datapath and a single-port, byte-addressed data memory. The datapath presents a load step that carries up to two independent load streams. Each stream asks for a 16-byte window that may start at any byte address. Each stream keeps a private 32-byte line buffer. A window that lies wholly inside its buffer is returned at once, with no memory traffic. Otherwise the block refills that buffer with a single 32-byte read, taken from the 16-byte boundary at or below the requested address. Typical traffic is a sliding input window with a small coefficient footprint. The first needs a read only every few steps, and the second needs a single read for a whole loop.

Stores arrive on a separate channel and are placed in a four-entry queue. A queued store is written to memory only in a cycle in which no refill read is issued, so stores never delay loads. When the queue is full, the oldest store is drained ahead of any read. Coherence is conservative. A load whose window overlaps a queued store waits until that store has been written. Writing a store invalidates any buffer whose range it touches, so a later load refetches the current data.

Top module: `lrb_core`

## Requirements
- R1: When `step_ready` is high, byte k of `ldN_data` (bits 8k+7..8k) is the most recent value of memory byte `ldN_addr`+k. This value includes every store accepted in an earlier cycle.
- R2: A refill issues one read (`mem_en`=1, `mem_we`=0) whose `mem_addr` is the stream address with its low 4 bits cleared. Byte j of `mem_rdata` (bits 8j+7..8j) is returned in the next cycle and holds address `mem_addr`+j for j = 0..31.
- R3: A load is a hit when its buffer is valid and all 16 bytes lie inside the 32 buffered bytes, including an offset of exactly 16. A step whose enabled loads all hit is ready in the cycle it is presented and issues no read.
- R4: A step with a single miss issues its read in the cycle it is presented and becomes ready two cycles later.
- R5: When both streams miss in the same step, stream 0 reads first and stream 1 reads in the next cycle. The step becomes ready three cycles after it is presented.
- R6: A store is accepted when `st_valid` and `st_ready` are both high. Accepted stores are written (`mem_we`=1) in the order they were accepted, with their full byte address and 16 data bytes. A store is written only in a cycle with no refill read.
- R7: The queue holds 4 stores. While it is full, `st_ready` is low and the oldest store is written in that cycle, ahead of any pending refill.
- R8: A load whose window overlaps a queued store is not a hit. It waits until the store is written, refills, and then returns the stored bytes.
- R9: Reset and `flush` clear both buffers. After reset `step_ready` and `mem_en` are low and `st_ready` is high. The first load after reset or a flush is a miss.
- R10: `step_ready` is high only while `step_valid` is high. A stream whose enable is low counts as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate both stream buffers |
| step_valid | input | 1 | Load step presented |
| step_ready | output | 1 | Load step completes this cycle |
| ld0_en | input | 1 | Stream 0 active in this step |
| ld0_addr | input | AW | Stream 0 window start byte address |
| ld0_data | output | 8*LB | Stream 0 window bytes |
| ld1_en | input | 1 | Stream 1 active in this step |
| ld1_addr | input | AW | Stream 1 window start byte address |
| ld1_data | output | 8*LB | Stream 1 window bytes |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store queue can accept |
| st_addr | input | AW | Store start byte address |
| st_data | input | 8*LB | Store bytes |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | 8*LB | Write bytes |
| mem_rdata | input | 16*LB | Read bytes, one cycle after the read |

## Verification
The full-queue drain is the hardest state to reach. Reads and writes share the port, and a store leaves the queue in every cycle without a refill, so normal traffic keeps the queue nearly empty. The bench holds `flush` high while a load step is pending, which forces a refill read in every cycle, and streams stores at the same time until the queue fills. The load-over-queued-store case is reached by pairing a store with a step in which the other stream misses. The store then stays queued for the one cycle in which the overlapping load sees it.

// File: rtl/lrb_core.sv
module lrb_core #(
  parameter int AW = 20,
  parameter int LB = 16,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic              ld0_en,
  input  logic [AW-1:0]     ld0_addr,
  output logic [LB*8-1:0]   ld0_data,
  input  logic              ld1_en,
  input  logic [AW-1:0]     ld1_addr,
  output logic [LB*8-1:0]   ld1_data,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [AW-1:0]     st_addr,
  input  logic [LB*8-1:0]   st_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LB*8-1:0]   mem_wdata,
  input  logic [LB*16-1:0]  mem_rdata
);
  localparam int WB   = LB * 8;
  localparam int BB   = 2 * WB;
  localparam int OFFW = $clog2(LB);
  localparam int QAW  = $clog2(QDEPTH);

  function automatic logic near(input logic [AW-1:0] x, input logic [AW-1:0] y, input int lim);
    logic [AW-1:0] d;
    d = x - y + AW'(LB - 1);
    return d < AW'(lim);
  endfunction

  logic [AW-1:0] la [2];
  logic [AW-1:0] base [2];
  logic [AW-1:0] off [2];
  logic [BB-1:0] bufd [2];
  logic [WB-1:0] ldd [2];
  logic [1:0] len, bvalid, pend, inwin, ovl, hit, need, rd;

  logic [AW-1:0] qa [QDEPTH];
  logic [WB-1:0] qd [QDEPTH];
  logic [QAW-1:0] qhd, qtl;
  logic [QAW:0] qcnt;
  logic qfull, push, drain;
  logic [AW-1:0] head_a, rd_a;

  assign la[0] = ld0_addr;
  assign la[1] = ld1_addr;
  assign len = {ld1_en, ld0_en};
  assign ld0_data = ldd[0];
  assign ld1_data = ldd[1];

  assign qfull = qcnt == (QAW+1)'(QDEPTH);
  assign st_ready = ~qfull;
  assign push = st_valid & ~qfull;
  assign drain = (qcnt != '0) && (qfull || need == 2'b00);
  assign rd[0] = ~drain & need[0];
  assign rd[1] = ~drain & ~need[0] & need[1];
  assign head_a = qa[qhd];
  assign rd_a = rd[0] ? la[0] : la[1];

  assign mem_en = drain | rd[0] | rd[1];
  assign mem_we = drain;
  assign mem_addr = drain ? head_a : {rd_a[AW-1:OFFW], {OFFW{1'b0}}};
  assign mem_wdata = qd[qhd];
  assign step_ready = step_valid & hit[0] & hit[1];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      off[s] = la[s] - base[s];
      inwin[s] = bvalid[s] && (off[s] <= AW'(LB));
      ovl[s] = 1'b0;
      for (int q = 0; q < QDEPTH; q++)
        if (((QAW+1)'(q) < qcnt) && near(la[s], qa[qhd + QAW'(q)], 2*LB - 1))
          ovl[s] = 1'b1;
      hit[s] = ~len[s] | (inwin[s] & ~ovl[s]);
      need[s] = step_valid & len[s] & ~inwin[s] & ~ovl[s] & ~pend[s];
      ldd[s] = WB'(bufd[s] >> {off[s][OFFW:0], 3'b000});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= '0;
      pend <= '0;
      for (int s = 0; s < 2; s++) base[s] <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        pend[s] <= rd[s] & ~flush;
        if (rd[s]) base[s] <= {la[s][AW-1:OFFW], {OFFW{1'b0}}};
        if (flush || rd[s]) bvalid[s] <= 1'b0;
        else if (drain && near(head_a, base[s], 3*LB - 1)) bvalid[s] <= 1'b0;
        else if (pend[s]) bvalid[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++)
      if (pend[s]) bufd[s] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qhd <= '0;
      qtl <= '0;
      qcnt <= '0;
    end else begin
      if (push) qtl <= qtl + 1'b1;
      if (drain) qhd <= qhd + 1'b1;
      qcnt <= qcnt + {{QAW{1'b0}}, push} - {{QAW{1'b0}}, drain};
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      qa[qtl] <= st_addr;
      qd[qtl] <= st_data;
    end
  end
endmodule

// File: rtl/lrb_core_chk.sv
module lrb_core_chk #(
  parameter int AW = 20,
  parameter int LB = 16,
  parameter int QDEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          step_valid,
  input logic          step_ready,
  input logic          ld0_en,
  input logic          st_ready,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [$clog2(QDEPTH):0] qcnt
);
  localparam int OFFW = $clog2(LB);

  assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_ready |-> step_valid);

  assert_refill_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_addr[OFFW-1:0] == '0));

  assert_flush_forces_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && ld0_en) |-> !step_ready);

  assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= ($clog2(QDEPTH)+1)'(QDEPTH));

  assert_full_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt == ($clog2(QDEPTH)+1)'(QDEPTH)) |-> (mem_en && mem_we && !st_ready));

  assert_write_has_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && qcnt != '0));
endmodule

bind lrb_core lrb_core_chk #(.AW(AW), .LB(LB), .QDEPTH(QDEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .step_valid(step_valid),
  .step_ready(step_ready), .ld0_en(ld0_en), .st_ready(st_ready),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .qcnt(qcnt)
);

// File: tb/lrb_core_tb_top.sv
module lrb_core_tb_top;
  localparam int AW = 20;
  localparam int LB = 16;
  localparam int WB = LB * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, flush, step_valid, step_ready, ld0_en, ld1_en, st_valid, st_ready;
  logic mem_en, mem_we;
  logic [AW-1:0] ld0_addr, ld1_addr, st_addr, mem_addr;
  logic [WB-1:0] ld0_data, ld1_data, st_data, mem_wdata;
  logic [2*WB-1:0] mem_rdata;

  lrb_core dut_i (.*);

  int total = 0, bad = 0, cyc = 0, fullseen = 0;
  bit done = 0;
  logic [7:0] mem [int];
  logic [7:0] arch [int];
  typedef struct { logic [AW-1:0] a; logic [WB-1:0] d; } st_t;
  st_t sq[$];
  logic [AW:0] ops[$];

  function automatic logic [7:0] seed(int a);
    return 8'(a * 13 + (a >>> 8) * 7 + 3);
  endfunction
  function automatic logic [7:0] getm(int a);
    return mem.exists(a) ? mem[a] : seed(a);
  endfunction
  function automatic logic [7:0] geta(int a);
    return arch.exists(a) ? arch[a] : seed(a);
  endfunction
  function automatic logic [WB-1:0] win(logic [AW-1:0] a);
    logic [WB-1:0] r;
    for (int k = 0; k < LB; k++) r[8*k +: 8] = geta(int'(a) + k);
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) for (int k = 0; k < LB; k++) mem[int'(mem_addr) + k] = mem_wdata[8*k +: 8];
      else for (int k = 0; k < 2*LB; k++) mem_rdata[8*k +: 8] <= getm(int'(mem_addr) + k);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sq.size() == 4) begin
        fullseen++;
        chk(!st_ready && mem_en && mem_we, "R7 full drain", {st_ready, mem_en, mem_we}, 3'b011);
      end
      if (mem_en) begin
        ops.push_back({mem_we, mem_addr});
        if (!mem_we) chk(mem_addr[3:0] == 4'h0, "R2 aligned", mem_addr, {mem_addr[AW-1:4], 4'h0});
        else if (sq.size() == 0) chk(0, "R6 write without store", mem_addr, 0);
        else begin
          chk(mem_addr == sq[0].a && mem_wdata == sq[0].d, "R6 order", {mem_addr, mem_wdata}, {sq[0].a, sq[0].d});
          void'(sq.pop_front());
        end
      end
      if (step_ready) begin
        chk(step_valid, "R10 ready w/o valid", step_ready, 0);
        if (ld0_en) chk(ld0_data == win(ld0_addr), "R1 stream0", ld0_data, win(ld0_addr));
        if (ld1_en) chk(ld1_data == win(ld1_addr), "R1 stream1", ld1_data, win(ld1_addr));
      end
      if (st_valid && st_ready) begin
        sq.push_back('{st_addr, st_data});
        for (int k = 0; k < LB; k++) arch[int'(st_addr) + k] = st_data[8*k +: 8];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      total++; bad++;
      $display("FAIL R4 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(bit e0, logic [AW-1:0] a0, bit e1, logic [AW-1:0] a1, output int waits);
    waits = 0;
    ld0_en = e0; ld0_addr = a0; ld1_en = e1; ld1_addr = a1; step_valid = 1;
    @(negedge clk);
    while (!step_ready) begin waits++; @(negedge clk); end
    @(posedge clk); #1;
    step_valid = 0; ld0_en = 0; ld1_en = 0;
  endtask

  task automatic push_store(logic [AW-1:0] a, logic [WB-1:0] d);
    st_valid = 1; st_addr = a; st_data = d;
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    @(posedge clk); #1;
    st_valid = 0;
  endtask

  initial begin
    int w;
    rst_n = 0; flush = 0; step_valid = 0; ld0_en = 0; ld1_en = 0; st_valid = 0;
    ld0_addr = '0; ld1_addr = '0; st_addr = '0; st_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!step_ready && st_ready && !mem_en, "R9 reset state", {step_ready, st_ready, mem_en}, 3'b010);
    @(posedge clk); #1;

    ops.delete();
    fork
      push_store(20'h10400, {8{16'hA5C3}});
      step(1, 20'h10000, 1, 20'h00000, w);
    join
    chk(w == 3, "R5 dual miss wait", w, 3);
    chk(ops.size() == 3 && ops[0] == {1'b0, 20'h10000} && ops[1] == {1'b0, 20'h00000}
        && ops[2] == {1'b1, 20'h10400}, "R5 R6 op order", ops.size(), 3);

    ops.delete();
    step(1, 20'h10001, 1, 20'h00001, w);
    chk(w == 0 && ops.size() == 0, "R3 hit", {w, ops.size()}, 0);

    ops.delete();
    step(1, 20'h10010, 1, 20'h00002, w);
    chk(w == 0 && ops.size() == 0, "R3 hit at offset 16", {w, ops.size()}, 0);

    ops.delete();
    step(1, 20'h10011, 1, 20'h00000, w);
    chk(w == 2, "R4 single miss wait", w, 2);
    chk(ops.size() == 1 && ops[0] == {1'b0, 20'h10010}, "R2 refill address", ops.size() ? ops[0] : 0, {1'b0, 20'h10010});

    step(1, 20'h10012, 0, 20'hFFFFF, w);
    chk(w == 0, "R10 disabled stream hits", w, 0);

    ops.delete();
    fork
      push_store(20'h1001C, 128'h0123456789ABCDEF_FEDCBA9876543210);
      step(1, 20'h10012, 1, 20'h00040, w);
    join
    chk(w == 4, "R8 overlap wait", w, 4);
    chk(ops.size() == 3 && ops[0] == {1'b0, 20'h00040} && ops[1] == {1'b1, 20'h1001C}
        && ops[2] == {1'b0, 20'h10010}, "R8 write before refill", ops.size(), 3);

    step(0, 20'h0, 0, 20'h0, w);
    chk(w == 0, "R10 empty step", w, 0);

    flush = 1;
    @(posedge clk); #1 flush = 0;
    step(1, 20'h10012, 1, 20'h00040, w);
    chk(w == 3, "R9 flush miss", w, 3);

    flush = 1;
    fork
      begin repeat (12) @(posedge clk); #1 flush = 0; end
      step(1, 20'h20000, 0, 20'h0, w);
      for (int k = 0; k < 6; k++) push_store(AW'(20'h30000 + 16 * k), {16{8'(k + 8'h40)}});
    join
    chk(fullseen > 0, "R7 queue filled", fullseen, 1);

    repeat (10) @(posedge clk); #1;
    chk(sq.size() == 0, "R6 all stores written", sq.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule